// File: doc/BRIEF.md
# Tagged Capability Slot Memory

This block is a single-port memory built from 128-bit slots. Next to each slot sits one tag bit, which ordinary data accesses can neither see nor set. A capability access reads or writes the whole slot together with its tag. A data access reads or writes 1, 2, 4 or 8 bytes inside a slot. The tag therefore marks the slot as holding an intact capability. Only a capability store can raise it. Any data store that touches the slot drops it.

A requester drives one request per cycle, using a byte address, a write strobe, a capability/data select and a size code. Stores complete at the clock edge. Loads, and the error flag for any rejected request, come back on registered outputs one cycle later. Misaligned requests are refused and change nothing.

Top module: `cap_mem`

## Requirements
- R1: After reset every slot's tag is zero, and `rvalid_o`, `err_o` and `rtag_o` are low until a request arrives.
- R2: A capability store (`cap_i`=1, `we_i`=1) to an address with `addr_i[3:0]`=0 writes all 128 bits of slot `addr_i>>4` and sets its tag to `wtag_i`. A capability load of the same slot returns those 128 bits and that tag.
- R3: A capability store with `wtag_i`=0 to a tagged slot leaves the slot's tag at zero, while the data is still written.
- R4: A data store writes `wdata_i[8N-1:0]` into the N bytes starting at byte `addr_i[3:0]` of the slot, with N = 1, 2, 4 or 8 for `size_i` = 0, 1, 2 or 3. Every other byte of every slot keeps its value.
- R5: An accepted data store clears the tag of the slot it touches. The tags of all other slots keep their values.
- R6: A data load returns the N addressed bytes right-justified in `rdata_o`, with all upper bits zero and `rtag_o`=0, even when the slot is tagged.
- R7: A capability access with `addr_i[3:0]`≠0 is rejected with `err_o`=1 one cycle later, and no slot data or tag changes.
- R8: A data access whose byte offset is not a multiple of N is rejected with `err_o`=1 one cycle later, and no slot data or tag changes.
- R9: `rvalid_o` is high exactly in the cycle after a load request. A rejected load returns `rdata_o`=0 and `rtag_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request valid this cycle |
| we_i | input | 1 | 1 = store, 0 = load |
| cap_i | input | 1 | 1 = capability (128-bit) access, 0 = data access |
| size_i | input | 2 | Data access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| addr_i | input | ADDR_W | Byte address; slot = addr_i>>4 |
| wdata_i | input | 128 | Store data (data stores use the low bytes) |
| wtag_i | input | 1 | Tag written by a capability store |
| rvalid_o | output | 1 | Load response valid |
| rdata_o | output | 128 | Load data |
| rtag_o | output | 1 | Tag of a capability load, else 0 |
| err_o | output | 1 | Previous request was misaligned and rejected |

## Verification
A data store changes two things at the same clock edge: it merges the addressed bytes into the slot and it clears the slot's tag. The bench drives partial data stores of every size into slots it has just filled with tagged capabilities. A later capability load must then show the merged bytes, every untouched byte unchanged and the tag low. The second overlap is rejection against writing: misaligned capability and data stores are aimed at tagged slots. Read-back must then show both the contents and the tag intact.

// File: rtl/cap_mem_pkg.sv
package cap_mem_pkg;
  localparam int SLOT_BYTES = 16;
  localparam int SLOT_W     = SLOT_BYTES * 8;
  localparam int OFF_W      = $clog2(SLOT_BYTES);

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } size_e;
endpackage

// File: rtl/cap_mem_decode.sv
module cap_mem_decode
  import cap_mem_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int IDX_W = ADDR_W - OFF_W
) (
  input  logic                  cap_i,
  input  logic [1:0]            size_i,
  input  logic [ADDR_W-1:0]     addr_i,
  output logic                  ok_o,
  output logic [IDX_W-1:0]      idx_o,
  output logic [OFF_W-1:0]      off_o,
  output logic [SLOT_BYTES-1:0] be_o
);
  logic [SLOT_BYTES-1:0] mask;

  assign idx_o = addr_i[ADDR_W-1:OFF_W];
  assign off_o = addr_i[OFF_W-1:0];

  always_comb begin
    ok_o = 1'b0;
    mask = '0;
    if (cap_i) begin
      ok_o = (off_o == '0);
      mask = '1;
    end else begin
      unique case (size_e'(size_i))
        SZ_B: begin ok_o = 1'b1;                mask = 16'h0001; end
        SZ_H: begin ok_o = (off_o[0] == 1'b0);  mask = 16'h0003; end
        SZ_W: begin ok_o = (off_o[1:0] == '0);  mask = 16'h000f; end
        SZ_D: begin ok_o = (off_o[2:0] == '0);  mask = 16'h00ff; end
        default: begin ok_o = 1'b0;             mask = '0;       end
      endcase
    end
  end

  // cap access always has off 0 when accepted, so shift is harmless
  assign be_o = cap_i ? mask : (mask << off_o);
endmodule

// File: rtl/cap_mem_array.sv
module cap_mem_array
  import cap_mem_pkg::*;
#(
  parameter int SLOTS = 16,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                  clk_i,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [SLOT_BYTES-1:0] be_i,
  input  logic [SLOT_W-1:0]     wdata_i,
  output logic [SLOT_W-1:0]     rdata_o
);
  for (genvar g = 0; g < SLOT_BYTES; g++) begin : g_lane
    logic [7:0] lane_q [SLOTS];
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[g]) lane_q[idx_i] <= wdata_i[g*8 +: 8];
    end
    assign rdata_o[g*8 +: 8] = lane_q[idx_i];
  end
endmodule

// File: rtl/cap_mem_tags.sv
module cap_mem_tags #(
  parameter int SLOTS = 16,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             val_i,
  output logic             tag_o
);
  logic [SLOTS-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tag_q <= '0;
    else if (we_i) tag_q[idx_i] <= val_i;
  end

  assign tag_o = tag_q[idx_i];
endmodule

// File: rtl/cap_mem.sv
module cap_mem
  import cap_mem_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              cap_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [127:0]      wdata_i,
  input  logic              wtag_i,
  output logic              rvalid_o,
  output logic [127:0]      rdata_o,
  output logic              rtag_o,
  output logic              err_o
);
  localparam int IDX_W = ADDR_W - OFF_W;
  localparam int SLOTS = 2 ** IDX_W;

  logic                  ok;
  logic [IDX_W-1:0]      idx;
  logic [OFF_W-1:0]      off;
  logic [SLOT_BYTES-1:0] be;
  logic [SLOT_W-1:0]     wlane, raw, rshift, rfmt, dmask;
  logic                  tag_cur, wr_go;

  cap_mem_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cap_i (cap_i), .size_i(size_i), .addr_i(addr_i),
    .ok_o  (ok),    .idx_o (idx),    .off_o (off),   .be_o(be)
  );

  assign wr_go = req_i && we_i && ok;
  assign wlane = cap_i ? wdata_i : ({64'b0, wdata_i[63:0]} << {off, 3'b000});

  cap_mem_array #(.SLOTS(SLOTS)) u_arr (
    .clk_i(clk_i), .we_i(wr_go), .idx_i(idx), .be_i(be),
    .wdata_i(wlane), .rdata_o(raw)
  );

  // data stores force the tag low; cap stores write the supplied tag
  cap_mem_tags #(.SLOTS(SLOTS)) u_tag (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_go), .idx_i(idx),
    .val_i(cap_i & wtag_i), .tag_o(tag_cur)
  );

  always_comb begin
    unique case (size_e'(size_i))
      SZ_B:    dmask = {{120{1'b0}}, {8{1'b1}}};
      SZ_H:    dmask = {{112{1'b0}}, {16{1'b1}}};
      SZ_W:    dmask = {{96{1'b0}}, {32{1'b1}}};
      default: dmask = {{64{1'b0}}, {64{1'b1}}};
    endcase
  end

  assign rshift = raw >> {off, 3'b000};
  assign rfmt   = cap_i ? raw : (rshift & dmask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
      rdata_o  <= '0;
      rtag_o   <= 1'b0;
    end else begin
      rvalid_o <= req_i && !we_i;
      err_o    <= req_i && !ok;
      rdata_o  <= (req_i && !we_i && ok) ? rfmt : '0;
      rtag_o   <= req_i && !we_i && ok && cap_i && tag_cur;
    end
  end
endmodule

// File: rtl/cap_mem_chk.sv
module cap_mem_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic              cap_i,
  input logic [1:0]        size_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rvalid_o,
  input logic [127:0]      rdata_o,
  input logic              rtag_o,
  input logic              err_o
);
  AST_RVALID_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i)); // R9
  AST_LOAD_GETS_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o); // R9
  AST_CAP_MISALIGN_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cap_i && addr_i[3:0] != 4'd0) |=> err_o); // R7
  AST_DATA_MISALIGN_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !cap_i && size_i == 2'd3 && addr_i[2:0] != 3'd0) |=> err_o); // R8
  AST_ERR_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i)); // R8
  AST_DATA_LOAD_NO_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !$past(cap_i)) |-> (!rtag_o && rdata_o[127:64] == 64'd0)); // R6
  AST_BYTE_LOAD_ZERO_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(!cap_i && size_i == 2'd0)) |-> rdata_o[127:8] == 120'd0); // R6
  AST_ERR_LOAD_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && err_o) |-> (rdata_o == 128'd0 && !rtag_o)); // R9
endmodule

bind cap_mem cap_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .cap_i(cap_i),
  .size_i(size_i), .addr_i(addr_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
  .rtag_o(rtag_o), .err_o(err_o)
);

// File: tb/sim_cap_mem.sv
module sim_cap_mem;
  localparam int ADDR_W = 8;
  localparam int SLOTS  = 2 ** (ADDR_W - 4);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0, we_i = 1'b0, cap_i = 1'b0, wtag_i = 1'b0;
  logic [1:0]        size_i = '0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [127:0]      wdata_i = '0;
  logic              rvalid_o, rtag_o, err_o;
  logic [127:0]      rdata_o;

  cap_mem #(.ADDR_W(ADDR_W)) u0 (.*);

  always #5 clk_i = ~clk_i;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  logic [127:0] m_data [SLOTS];
  logic [15:0]  m_known [SLOTS];
  logic         m_tag [SLOTS];

  task automatic chk(input bit good, input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic int nbytes(input bit cap, input logic [1:0] sz);
    return cap ? 16 : (1 << sz);
  endfunction

  function automatic bit aligned(input bit cap, input logic [1:0] sz, input logic [7:0] a);
    return (int'(a[3:0]) % nbytes(cap, sz)) == 0;
  endfunction

  task automatic op(input bit we, input bit cap, input logic [1:0] sz, input logic [7:0] a,
                    input logic [127:0] wd, input bit wt, input string rq);
    int s = int'(a[7:4]);
    int o = int'(a[3:0]);
    int n = nbytes(cap, sz);
    bit ok = aligned(cap, sz, a);
    logic [127:0] exp = '0, msk = '0;
    bit etag = 1'b0;
    if (ok && !we) begin
      for (int b = 0; b < n; b++) begin
        exp[b*8 +: 8] = m_data[s][(o+b)*8 +: 8];
        if (m_known[s][o+b]) msk[b*8 +: 8] = 8'hff;
      end
      for (int b = n; b < 16; b++) msk[b*8 +: 8] = 8'hff;
      etag = cap && m_tag[s];
    end else if (!we) msk = '1;
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; cap_i = cap; size_i = sz; addr_i = a; wdata_i = wd; wtag_i = wt;
    @(negedge clk_i);
    req_i = 1'b0;
    chk(err_o == !ok, {rq, " err"}, {127'd0, err_o}, {127'd0, !ok});
    chk(rvalid_o == !we, {rq, " rvalid"}, {127'd0, rvalid_o}, {127'd0, !we});
    if (!we) begin
      chk((rdata_o & msk) == (exp & msk), {rq, " rdata"}, rdata_o & msk, exp & msk);
      chk(rtag_o == etag, {rq, " rtag"}, {127'd0, rtag_o}, {127'd0, etag});
    end else if (ok) begin
      for (int b = 0; b < n; b++) begin
        m_data[s][(o+b)*8 +: 8] = wd[b*8 +: 8];
        m_known[s][o+b] = 1'b1;
      end
      m_tag[s] = cap ? wt : 1'b0;
    end
  endtask

  initial begin
    for (int i = 0; i < SLOTS; i++) begin m_data[i] = '0; m_known[i] = '0; m_tag[i] = 1'b0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: idle outputs and cleared tags
    chk(!rvalid_o && !err_o && !rtag_o, "R1 idle", {125'd0, rvalid_o, err_o, rtag_o}, '0);
    for (int i = 0; i < SLOTS; i++) op(0, 1, 0, 8'(i << 4), '0, 0, "R1 tag");

    op(1, 1, 0, 8'h20, {64'hc0de_0000_1111_2222, 64'h3333_4444_5555_6666}, 1, "R2 store");
    op(0, 1, 0, 8'h20, '0, 0, "R2 load");
    // R4 R5: partial writes into tagged slots, every size
    for (int z = 0; z < 4; z++) begin
      op(1, 1, 0, 8'h30, {$urandom, $urandom, $urandom, $urandom}, 1, "R2 fill");
      op(1, 0, 2'(z), 8'h38, {$urandom, $urandom, $urandom, $urandom}, 0, "R4 store");
      op(0, 1, 0, 8'h30, '0, 0, "R5 cap check");
      op(0, 1, 0, 8'h20, '0, 0, "R5 other slot");
    end
    // R6: data load of tagged slot shows no tag
    op(1, 1, 0, 8'h40, {$urandom, $urandom, $urandom, $urandom}, 1, "R2 fill");
    op(0, 0, 3, 8'h48, '0, 0, "R6 dword");
    op(0, 0, 0, 8'h4f, '0, 0, "R6 byte");
    // R3
    op(1, 1, 0, 8'h40, {$urandom, $urandom, $urandom, $urandom}, 0, "R3 store");
    op(0, 1, 0, 8'h40, '0, 0, "R3 load");
    // R7 R8 R9
    op(1, 1, 0, 8'h50, {4{32'h5a5a_a5a5}}, 1, "R2 fill");
    op(1, 1, 0, 8'h58, '1, 0, "R7 store");
    op(0, 1, 0, 8'h54, '0, 0, "R9 err load");
    op(1, 0, 2, 8'h52, '1, 0, "R8 store");
    op(1, 0, 1, 8'h55, '1, 0, "R8 half");
    op(0, 0, 3, 8'h5c, '0, 0, "R9 err data load");
    op(0, 1, 0, 8'h50, '0, 0, "R7 R8 unchanged");
    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [7:0] a = 8'($urandom);
      bit cap = ($urandom % 3) == 0;
      logic [1:0] sz = 2'($urandom);
      if (($urandom % 4) != 0) a[3:0] = cap ? 4'd0 : (a[3:0] & ~4'((1 << sz) - 1));
      op(bit'($urandom), cap, sz, a, {$urandom, $urandom, $urandom, $urandom},
         bit'($urandom), "R4 R5 R6 R7 R8 random");
    end
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule